// File: doc/BRIEF.md
# Status-Register NOR Flash Command Engine

This block is the bus master that drives a 16-bit NOR flash part with a status-register command set. A host pulses a request with an operation code, a target address, a data word and an unlock enable. The engine then issues the command words in order on a simple single-cycle write strobe. It polls the part's status word with a read strobe until the ready bit is set, and always writes the read-array command before it reports completion.

Four operations are supported: word program, block erase, erase suspend and erase resume. A suspend may interrupt the engine while it is polling an erase; it stops that polling and suspends the erase. The suspend then checks the erase-suspended status bit to learn whether the erase had in fact already finished. The engine keeps a two-bit device state for the host. It latches the failure bits of the final status word and presents them with the completion pulse.

On the flash side, read data must be valid from the cycle after the read strobe until the next read strobe. Command words are zero-extended to the data width.

Top module: `nor_sr_engine`

## Requirements
- R1: After reset, busy, done, err, erase_fin, f_we and f_re are all 0, and dev_state is 0 (read).
- R2: A program request writes 0x60, 0xD0, 0x50, 0x40 and then the data word when unlock_en is 1, or only 0x40 and then the data word when it is 0. All of these go to the target address on consecutive cycles.
- R3: An erase request writes 0x60, 0xD0, 0x50, 0x20, 0xD0 when unlock_en is 1, or 0x50, 0x20, 0xD0 when it is 0. All of these go to the block address on consecutive cycles.
- R4: After its command words, the engine reads the target address again and again until a status word has bit 7 set. It makes exactly one read for each not-ready status plus one for the ready status.
- R5: Every completed operation writes 0xFF to its address and then pulses done for one cycle. busy falls in the same cycle. After a program or erase, dev_state is 0 (read).
- R6: When an operation completes, err takes status bit 1 into err[0], bit 3 into err[1], bit 4 into err[2] and bit 5 into err[3]. err and erase_fin hold their values until the next accepted request clears them.
- R7: A suspend request (op 2) is accepted while an erase or resume is polling. The engine stops that polling, writes 0xB0 and then 0x70 to the block address, and polls bit 7.
- R8: If the suspend's final status has bit 6 set, dev_state becomes 3 (suspended) and erase_fin is 0. If bit 6 is clear, dev_state becomes 0 and erase_fin is 1. In both cases 0xFF is written before done.
- R9: A resume request (op 3) is accepted only in state 3. It writes 0xD0 and then 0x70 to the saved block address, whatever cmd_addr is. It sets dev_state to 2 (erase), then polls and completes as an erase does.
- R10: The following requests are ignored, with no bus cycle, no done and no change of dev_state: any request while busy other than the R7 case, a suspend when no erase is running, a resume when not suspended, and a program or erase while suspended.
- R11: From the cycle after acceptance, dev_state is 1 (write) during a program and 2 (erase) during an erase or resume. It is 3 from the moment a suspend is accepted.
- R12: f_we and f_re are never high together, and neither is high while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Request strobe, one cycle |
| cmd_op | input | 2 | 0 program, 1 erase, 2 suspend, 3 resume |
| cmd_addr | input | AW | Target word or block address |
| cmd_data | input | DW | Word to program |
| unlock_en | input | 1 | Issue unlock and clear-status words |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 4 | Latched status failure bits |
| erase_fin | output | 1 | Suspend found the erase already complete |
| dev_state | output | 2 | 0 read, 1 write, 2 erase, 3 suspended |
| f_addr | output | AW | Flash address |
| f_wdata | output | DW | Flash write data |
| f_we | output | 1 | Flash write strobe |
| f_re | output | 1 | Flash read strobe |
| f_rdata | input | DW | Flash read data, valid the cycle after f_re |

## Verification
The assertions check every cycle that the strobes never overlap and stay quiet while idle, and that done is a single pulse that follows a 0xFF write and drops busy. They also check that the write state is never left behind when idle, that the address holds steady across a burst of words, that the device state holds while idle, and that erase_fin never coexists with the suspended state when idle. Only the bench scenarios can show that the exact word sequences and the read counts are correct, and that error bits map as specified. The same holds for the two outcomes of a suspend, for a resume going back to the saved block address, and for each kind of ignored request leaving the bus silent.

// File: rtl/nor_sr_pkg.sv
package nor_sr_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_ERASE = 2'd1, OP_SUSP = 2'd2, OP_RESUME = 2'd3} op_e;
  typedef enum logic [1:0] {DS_READ = 2'd0, DS_WRITE = 2'd1, DS_ERASE = 2'd2, DS_SUSP = 2'd3} dstate_e;

  localparam logic [7:0] CW_CFG_SETUP = 8'h60;
  localparam logic [7:0] CW_CONFIRM   = 8'hD0;
  localparam logic [7:0] CW_CLR_STAT  = 8'h50;
  localparam logic [7:0] CW_PROGRAM   = 8'h40;
  localparam logic [7:0] CW_ERASE     = 8'h20;
  localparam logic [7:0] CW_SUSPEND   = 8'hB0;
  localparam logic [7:0] CW_RD_STAT   = 8'h70;
  localparam logic [7:0] CW_RD_ARRAY  = 8'hFF;

  localparam int SB_READY   = 7;
  localparam int SB_SUSP    = 6;
  localparam int SB_ERFAIL  = 5;
  localparam int SB_PGFAIL  = 4;
  localparam int SB_VOLT    = 3;
  localparam int SB_LOCKED  = 1;

  localparam int SEQ_MAX   = 5;
  localparam int SEQ_IDX_W = $clog2(SEQ_MAX + 1);
endpackage

// File: rtl/nor_sr_seq.sv
module nor_sr_seq
  import nor_sr_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e                  op,
  input  logic                 unl,
  input  logic [DW-1:0]        data,
  input  logic [SEQ_IDX_W-1:0] idx,
  output logic [DW-1:0]        word,
  output logic [SEQ_IDX_W-1:0] len
);
  function automatic logic [DW-1:0] cw(input logic [7:0] c);
    return {{(DW-8){1'b0}}, c};
  endfunction

  always_comb begin
    word = cw(CW_RD_STAT);
    len  = SEQ_IDX_W'(2);
    unique case (op)
      OP_PROG: begin
        if (unl) begin
          len = SEQ_IDX_W'(5);
          case (idx)
            SEQ_IDX_W'(0): word = cw(CW_CFG_SETUP);
            SEQ_IDX_W'(1): word = cw(CW_CONFIRM);
            SEQ_IDX_W'(2): word = cw(CW_CLR_STAT);
            SEQ_IDX_W'(3): word = cw(CW_PROGRAM);
            default:       word = data;
          endcase
        end else begin
          len  = SEQ_IDX_W'(2);
          word = (idx == '0) ? cw(CW_PROGRAM) : data;
        end
      end
      OP_ERASE: begin
        if (unl) begin
          len = SEQ_IDX_W'(5);
          case (idx)
            SEQ_IDX_W'(0): word = cw(CW_CFG_SETUP);
            SEQ_IDX_W'(1): word = cw(CW_CONFIRM);
            SEQ_IDX_W'(2): word = cw(CW_CLR_STAT);
            SEQ_IDX_W'(3): word = cw(CW_ERASE);
            default:       word = cw(CW_CONFIRM);
          endcase
        end else begin
          len = SEQ_IDX_W'(3);
          case (idx)
            SEQ_IDX_W'(0): word = cw(CW_CLR_STAT);
            SEQ_IDX_W'(1): word = cw(CW_ERASE);
            default:       word = cw(CW_CONFIRM);
          endcase
        end
      end
      OP_SUSP: begin
        len  = SEQ_IDX_W'(2);
        word = (idx == '0) ? cw(CW_SUSPEND) : cw(CW_RD_STAT);
      end
      default: begin
        len  = SEQ_IDX_W'(2);
        word = (idx == '0) ? cw(CW_CONFIRM) : cw(CW_RD_STAT);
      end
    endcase
  end
endmodule

// File: rtl/nor_sr_status.sv
module nor_sr_status
  import nor_sr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rdata,
  output logic          ready,
  output logic          suspended,
  output logic [3:0]    fail
);
  assign ready     = rdata[SB_READY];
  assign suspended = rdata[SB_SUSP];
  assign fail      = {rdata[SB_ERFAIL], rdata[SB_PGFAIL], rdata[SB_VOLT], rdata[SB_LOCKED]};
endmodule

// File: rtl/nor_sr_engine.sv
module nor_sr_engine
  import nor_sr_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_go,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          unlock_en,
  output logic          busy,
  output logic          done,
  output logic [3:0]    err,
  output logic          erase_fin,
  output logic [1:0]    dev_state,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_wdata,
  output logic          f_we,
  output logic          f_re,
  input  logic [DW-1:0] f_rdata
);
  localparam logic [DW-1:0] RD_ARRAY_W = {{(DW-8){1'b0}}, CW_RD_ARRAY};

  typedef enum logic [2:0] {E_IDLE, E_SEQ, E_RD, E_CHK, E_FIN} eng_e;

  eng_e                 st;
  op_e                  op_q;
  dstate_e              ds_q;
  logic                 unl_q;
  logic [DW-1:0]        data_q;
  logic [AW-1:0]        tgt_q, blk_q;
  logic [SEQ_IDX_W-1:0] idx_q, seq_len;
  logic [DW-1:0]        seq_word;
  logic                 s_ready, s_susp;
  logic [3:0]           s_fail;
  op_e                  req_op;
  logic                 accept, preempt;

  nor_sr_seq #(.DW(DW)) u_seq (
    .op(op_q), .unl(unl_q), .data(data_q), .idx(idx_q), .word(seq_word), .len(seq_len)
  );

  nor_sr_status #(.DW(DW)) u_stat (
    .rdata(f_rdata), .ready(s_ready), .suspended(s_susp), .fail(s_fail)
  );

  assign req_op  = op_e'(cmd_op);
  assign accept  = cmd_go && (st == E_IDLE) &&
                   ((((req_op == OP_PROG) || (req_op == OP_ERASE)) && (ds_q == DS_READ)) ||
                    ((req_op == OP_RESUME) && (ds_q == DS_SUSP)));
  assign preempt = cmd_go && (req_op == OP_SUSP) && (ds_q == DS_ERASE) &&
                   ((st == E_RD) || (st == E_CHK));
  assign dev_state = ds_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_IDLE;
      op_q      <= OP_PROG;
      ds_q      <= DS_READ;
      unl_q     <= 1'b0;
      data_q    <= '0;
      tgt_q     <= '0;
      blk_q     <= '0;
      idx_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= '0;
      erase_fin <= 1'b0;
      f_addr    <= '0;
      f_wdata   <= '0;
      f_we      <= 1'b0;
      f_re      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        op_q      <= req_op;
        unl_q     <= unlock_en;
        data_q    <= cmd_data;
        idx_q     <= '0;
        busy      <= 1'b1;
        err       <= '0;
        erase_fin <= 1'b0;
        st        <= E_SEQ;
        if (req_op == OP_RESUME) begin
          tgt_q <= blk_q;
          ds_q  <= DS_ERASE;
        end else begin
          tgt_q <= cmd_addr;
          if (req_op == OP_ERASE) begin
            blk_q <= cmd_addr;
            ds_q  <= DS_ERASE;
          end else begin
            ds_q  <= DS_WRITE;
          end
        end
      end else if (preempt) begin
        op_q      <= OP_SUSP;
        idx_q     <= '0;
        tgt_q     <= blk_q;
        ds_q      <= DS_SUSP;
        err       <= '0;
        erase_fin <= 1'b0;
        f_re      <= 1'b0;
        st        <= E_SEQ;
      end else begin
        unique case (st)
          E_SEQ: begin
            if (idx_q < seq_len) begin
              f_we    <= 1'b1;
              f_wdata <= seq_word;
              f_addr  <= tgt_q;
              idx_q   <= idx_q + 1'b1;
            end else begin
              f_we <= 1'b0;
              f_re <= 1'b1;
              st   <= E_RD;
            end
          end
          E_RD: begin
            f_re <= 1'b0;
            st   <= E_CHK;
          end
          E_CHK: begin
            if (s_ready) begin
              err     <= s_fail;
              f_we    <= 1'b1;
              f_wdata <= RD_ARRAY_W;
              st      <= E_FIN;
              if (op_q == OP_SUSP) begin
                ds_q      <= s_susp ? DS_SUSP : DS_READ;
                erase_fin <= !s_susp;
              end else begin
                ds_q <= DS_READ;
              end
            end else begin
              f_re <= 1'b1;
              st   <= E_RD;
            end
          end
          E_FIN: begin
            f_we <= 1'b0;
            done <= 1'b1;
            busy <= 1'b0;
            st   <= E_IDLE;
          end
          default: st <= E_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/nor_sr_engine_chk.sv
module nor_sr_engine_chk
  import nor_sr_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          erase_fin,
  input logic [1:0]    dev_state,
  input logic [AW-1:0] f_addr,
  input logic [DW-1:0] f_wdata,
  input logic          f_we,
  input logic          f_re
);
  localparam logic [DW-1:0] RD_ARRAY_W = {{(DW-8){1'b0}}, CW_RD_ARRAY};

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(f_we && f_re)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (!f_we && !f_re)); // R12
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
  AST_DONE_AFTER_RDARR: assert property (@(posedge clk) disable iff (rst) done |-> ($past(f_we) && ($past(f_wdata) == RD_ARRAY_W))); // R5
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy))); // R5
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst) !busy |-> (dev_state != DS_WRITE)); // R11
  AST_FIN_IS_READ: assert property (@(posedge clk) disable iff (rst) (done && erase_fin) |-> (dev_state == DS_READ)); // R8
  AST_SUSP_NO_FIN: assert property (@(posedge clk) disable iff (rst) (!busy && (dev_state == DS_SUSP)) |-> !erase_fin); // R8
  AST_BURST_ADDR: assert property (@(posedge clk) disable iff (rst) (f_we && $past(f_we)) |-> $stable(f_addr)); // R2
  AST_IDLE_STATE_HOLD: assert property (@(posedge clk) disable iff (rst) (!busy && $past(!busy)) |-> $stable(dev_state)); // R10
endmodule

bind nor_sr_engine nor_sr_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .erase_fin(erase_fin),
  .dev_state(dev_state), .f_addr(f_addr), .f_wdata(f_wdata), .f_we(f_we), .f_re(f_re)
);

// File: tb/sim_nor_sr_engine.sv
`timescale 1ns/1ps
module sim_nor_sr_engine;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int LOGN = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_go = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          unlock_en = 1'b0;
  logic          busy, done, erase_fin, f_we, f_re;
  logic [3:0]    err;
  logic [1:0]    dev_state;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_wdata;
  logic [DW-1:0] f_rdata = '0;

  always #2.5 clk = ~clk;

  nor_sr_engine #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .unlock_en(unlock_en), .busy(busy), .done(done), .err(err),
    .erase_fin(erase_fin), .dev_state(dev_state), .f_addr(f_addr), .f_wdata(f_wdata),
    .f_we(f_we), .f_re(f_re), .f_rdata(f_rdata)
  );

  // flash model: state written only here
  int            wcount = 0, reads_total = 0, susp_base = 0, cycn = 0;
  logic          mode_susp = 1'b0;
  logic [DW-1:0] wlog_d [LOGN];
  logic [AW-1:0] wlog_a [LOGN];
  int            wlog_c [LOGN];
  logic [AW-1:0] last_raddr = '0;
  // model controls: written only by the stimulus process
  int            poll_base = 0, ready_after = 0, susp_ra = 0;
  logic [7:0]    fin_status = 8'h80, susp_status = 8'hC0;

  always @(negedge clk) begin
    cycn = cycn + 1;
    if (f_we) begin
      if (wcount < LOGN) begin
        wlog_d[wcount] = f_wdata;
        wlog_a[wcount] = f_addr;
        wlog_c[wcount] = cycn;
      end
      wcount = wcount + 1;
      if (f_wdata == 16'h00B0) begin
        mode_susp = 1'b1;
        susp_base = reads_total;
      end else if (f_wdata == 16'h00D0 || f_wdata == 16'h0040 || f_wdata == 16'h0060) begin
        mode_susp = 1'b0;
      end
    end
    if (f_re) begin
      last_raddr = f_addr;
      if (mode_susp) f_rdata = (reads_total - susp_base >= susp_ra) ? {8'h00, susp_status} : '0;
      else           f_rdata = (reads_total - poll_base >= ready_after) ? {8'h00, fin_status} : '0;
      reads_total = reads_total + 1;
    end
  end

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic unl, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_go = 1'b1; cmd_op = op; unlock_en = unl; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic chk_word(input int k, input logic [DW-1:0] w, input logic [AW-1:0] a, input string req);
    chk(wlog_d[k] == w, req, "write data", int'(wlog_d[k]), int'(w));
    chk(wlog_a[k] == a, req, "write addr", int'(wlog_a[k]), int'(a));
  endtask

  function automatic logic [DW-1:0] exp_word(input logic [1:0] op, input logic unl, input logic [DW-1:0] d, input int i);
    if (op == 2'd0) begin
      if (unl) case (i) 0: return 16'h60; 1: return 16'hD0; 2: return 16'h50; 3: return 16'h40; 4: return d; default: return 16'hFF; endcase
      else     case (i) 0: return 16'h40; 1: return d; default: return 16'hFF; endcase
    end
    if (unl) case (i) 0: return 16'h60; 1: return 16'hD0; 2: return 16'h50; 3: return 16'h20; 4: return 16'hD0; default: return 16'hFF; endcase
    else     case (i) 0: return 16'h50; 1: return 16'h20; 2: return 16'hD0; default: return 16'hFF; endcase
  endfunction

  function automatic int exp_len(input logic [1:0] op, input logic unl);
    if (op == 2'd0) return unl ? 6 : 3;
    return unl ? 6 : 4;
  endfunction

  typedef struct packed {
    logic [1:0] op; logic unl; logic [21:0] addr; logic [15:0] data;
    logic [7:0] ra; logic [7:0] st; logic [3:0] err;
  } vec_t;
  localparam int NV = 5;
  localparam logic [60:0] VECS [NV] = '{
    {2'd0, 1'b1, 22'h001234, 16'hBEEF, 8'd2, 8'h80, 4'h0},
    {2'd0, 1'b0, 22'h000002, 16'h1357, 8'd0, 8'h90, 4'h4},
    {2'd1, 1'b1, 22'h020000, 16'h0000, 8'd3, 8'h80, 4'h0},
    {2'd1, 1'b0, 22'h3F0000, 16'h0000, 8'd1, 8'hA2, 4'h9},
    {2'd0, 1'b1, 22'h0ABCDE, 16'h00FF, 8'd5, 8'h88, 4'h2}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    bit got;
    int lb, rb, n;
    logic [AW-1:0] blk;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !f_we && !f_re, "R1", "strobes/busy", {busy, done, f_we, f_re}, 0);
    chk(dev_state == 2'd0 && err == 4'h0 && !erase_fin, "R1", "state/err", {dev_state, err, erase_fin}, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = vec_t'(VECS[v]);
      poll_base = reads_total; ready_after = int'(t.ra); fin_status = t.st;
      lb = wcount; rb = reads_total;
      issue(t.op, t.unl, t.addr, t.data);
      chk(busy, "R11", "busy after accept", int'(busy), 1);
      chk(dev_state == ((t.op == 2'd0) ? 2'd1 : 2'd2), "R11", "state during op", int'(dev_state), (t.op == 2'd0) ? 1 : 2);
      wait_done(got);
      chk(got, "R5", "done seen", int'(got), 1);
      chk(!busy && dev_state == 2'd0, "R5", "idle read after done", {busy, dev_state}, 0);
      chk(err == t.err, "R6", "err bits", int'(err), int'(t.err));
      n = exp_len(t.op, t.unl);
      chk(wcount - lb == n, (t.op == 2'd0) ? "R2" : "R3", "write count", wcount - lb, n);
      for (int k = 0; k < n; k++)
        chk_word(lb + k, exp_word(t.op, t.unl, t.data, k), t.addr, (k == n - 1) ? "R5" : ((t.op == 2'd0) ? "R2" : "R3"));
      for (int k = 0; k < n - 2; k++)
        chk(wlog_c[lb + k + 1] == wlog_c[lb + k] + 1, (t.op == 2'd0) ? "R2" : "R3", "consecutive", wlog_c[lb + k + 1] - wlog_c[lb + k], 1);
      chk(reads_total - rb == int'(t.ra) + 1, "R4", "poll reads", reads_total - rb, int'(t.ra) + 1);
      chk(last_raddr == t.addr, "R4", "poll addr", int'(last_raddr), int'(t.addr));
      @(negedge clk);
      chk(!done, "R5", "done single pulse", int'(done), 0);
    end

    // R10: suspend and resume while idle in read state are ignored
    lb = wcount;
    issue(2'd2, 1'b0, 22'h000100, 16'h0);
    issue(2'd3, 1'b0, 22'h000100, 16'h0);
    repeat (6) @(negedge clk);
    chk(wcount == lb && !busy, "R10", "idle suspend/resume bus", wcount - lb, 0);
    chk(dev_state == 2'd0, "R10", "idle suspend/resume state", int'(dev_state), 0);

    // R10: request while a program is polling is ignored
    poll_base = reads_total; ready_after = 20; fin_status = 8'h80;
    lb = wcount;
    issue(2'd0, 1'b0, 22'h000400, 16'h00AA);
    repeat (3) @(negedge clk);
    issue(2'd1, 1'b1, 22'h010000, 16'h0);
    wait_done(got);
    chk(got && wcount - lb == 3, "R10", "busy request ignored", wcount - lb, 3);
    chk_word(lb, 16'h40, 22'h000400, "R10");
    chk(dev_state == 2'd0, "R10", "state after ignored", int'(dev_state), 0);

    // R7/R8: suspend an erase, still running (bit 6 set)
    blk = 22'h150000;
    poll_base = reads_total; ready_after = 10000; susp_ra = 2; susp_status = 8'hC0;
    lb = wcount;
    issue(2'd1, 1'b0, blk, 16'h0);
    repeat (8) @(negedge clk);
    chk(busy && dev_state == 2'd2, "R11", "erasing", {busy, dev_state}, 6);
    issue(2'd2, 1'b0, 22'h000000, 16'h0);
    chk(dev_state == 2'd3, "R11", "suspend state at accept", int'(dev_state), 3);
    wait_done(got);
    chk(got, "R7", "suspend done", int'(got), 1);
    chk(wcount - lb == 6, "R7", "write count", wcount - lb, 6);
    chk_word(lb + 3, 16'hB0, blk, "R7");
    chk_word(lb + 4, 16'h70, blk, "R7");
    chk_word(lb + 5, 16'hFF, blk, "R8");
    chk(dev_state == 2'd3 && !erase_fin, "R8", "suspended", {dev_state, erase_fin}, 6);

    // R10: program and suspend while suspended are ignored
    lb = wcount;
    issue(2'd0, 1'b1, 22'h000010, 16'h1234);
    issue(2'd2, 1'b0, 22'h000010, 16'h0);
    repeat (6) @(negedge clk);
    chk(wcount == lb && !busy && !done, "R10", "suspended ignores", wcount - lb, 0);
    chk(dev_state == 2'd3, "R10", "still suspended", int'(dev_state), 3);

    // R9: resume goes to the saved block address
    poll_base = reads_total; ready_after = 3; fin_status = 8'h80;
    lb = wcount;
    issue(2'd3, 1'b1, 22'h000777, 16'h0);
    chk(dev_state == 2'd2, "R9", "resume state", int'(dev_state), 2);
    wait_done(got);
    chk(got && wcount - lb == 3, "R9", "resume writes", wcount - lb, 3);
    chk_word(lb, 16'hD0, blk, "R9");
    chk_word(lb + 1, 16'h70, blk, "R9");
    chk_word(lb + 2, 16'hFF, blk, "R9");
    chk(dev_state == 2'd0, "R9", "read after resume", int'(dev_state), 0);

    // R8: suspend finds the erase complete (bit 6 clear), with erase-fail bit
    blk = 22'h2A0000;
    poll_base = reads_total; ready_after = 10000; susp_ra = 0; susp_status = 8'hA0;
    lb = wcount;
    issue(2'd1, 1'b1, blk, 16'h0);
    repeat (12) @(negedge clk);
    issue(2'd2, 1'b0, 22'h000000, 16'h0);
    wait_done(got);
    chk(got && dev_state == 2'd0 && erase_fin, "R8", "erase already done", {dev_state, erase_fin}, 1);
    chk(wcount - lb == 8, "R8", "write count", wcount - lb, 8);
    chk_word(lb + 5, 16'hB0, blk, "R7");
    chk_word(lb + 7, 16'hFF, blk, "R8");
    repeat (5) @(negedge clk);
    chk(err == 4'h8 && erase_fin, "R6", "flags held", {err, erase_fin}, 17);

    // R6: next accepted request clears flags
    poll_base = reads_total; ready_after = 0; fin_status = 8'h80;
    issue(2'd0, 1'b0, 22'h000020, 16'h0F0F);
    chk(err == 4'h0 && !erase_fin, "R6", "flags cleared", {err, erase_fin}, 0);
    wait_done(got);
    chk(got, "R5", "final done", int'(got), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule